// File: doc/BRIEF.md
# Serial Link Fault Injection Controller

This block sits in a combined UART/LIN receiver, between the receive pin path and the error detectors. In normal operation it passes each signal through unchanged. When it is put into test mode, it corrupts chosen signals so that each detector can be made to fire on purpose:
- the bit monitor (forced-one receive bit, either always or only during the break phase),
- the frame checker (forced-zero stop sample),
- the receive checksum unit (flipped checksum-type select),
- the sync-field checker (a skew request to the engine).

Software controls the block through one 32-bit control word on a simple write strobe bus. Each write carries a privilege qualifier, and the current link mode also qualifies it. The fault-enable group can change only while the link runs in LIN mode. The key field and the two path-select bits can change only on a privileged write. The frame-fault bit can always be written. Within one write, each field is accepted or dropped on its own.

A two-state mode machine tracks the key field:
- `ST_LOCKED` is the reset state.
- `KEY_MATCH`: a privileged write whose key field equals the unlock code (4'hA) moves `ST_LOCKED` to `ST_TEST`.
- `KEY_MISS`: a privileged write with any other key value moves `ST_TEST` back to `ST_LOCKED`.
- Any other cycle keeps the current state.

All injection, and the loopback and pin-select outputs, are gated by `ST_TEST`. The sync-error flag to the engine is held low in `ST_TEST`.

Top module: `rx_fault_inject`

## Requirements
- R1: After reset, `reg_rdata` reads 32'h0000_0500 (key field bits 11:8 = 4'h5, every other bit 0), and `test_active`, `lpbk_en` and `rxpin_en` are 0.
- R2: Reserved bits (bits 27, 25:12 and 7:2) always read 0, and writing 1 to them has no effect.
- R3: Bits 31 (bit fault), 30 (bus fault), 29 (checksum fault) and 28 (sync fault) take the written value only when `lin_mode` is 1 during the write. Otherwise they keep their value, while the other permitted fields of the same write still update.
- R4: The key field (bits 11:8), bit 1 (loopback) and bit 0 (pin select) take the written value only when `reg_priv` is 1 during the write. Otherwise they keep their value.
- R5: Bit 26 (frame fault) takes the written value on every write, whatever the mode and privilege.
- R6: `test_active` is 1 exactly when the key field holds 4'hA. When it is 0, every datapath output equals its input: `bitmon_bit`=`rx_bit`, `stopchk_bit`=`stop_bit`, `ctype_rx`=`ctype_sel`, `sync_err_flag`=`sync_err`, and `sync_skew_req`=0.
- R7: In test mode with bit 31 set, `bitmon_bit` is 1.
- R8: In test mode with bit 30 set, `bitmon_bit` is 1 while `brk_phase` is 1. While `brk_phase` is 0, it follows `rx_bit`.
- R9: In test mode with bit 29 set, `ctype_rx` is the inverse of `ctype_sel`.
- R10: In test mode with bit 26 set, `stopchk_bit` is 0.
- R11: In test mode, `sync_err_flag` is 0, and `sync_skew_req` equals bit 28.
- R12: Datapath outputs respond in the same cycle as their inputs. A write shows in `reg_rdata` and `test_active` after the first rising clock edge that samples the write strobe.
- R13: `lpbk_en` equals bit 1 and `rxpin_en` equals bit 0 while in test mode. Both are 0 outside test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_priv | input | 1 | Write is privileged |
| lin_mode | input | 1 | Link is operating in LIN mode |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word |
| test_active | output | 1 | Test mode is active (`ST_TEST`) |
| rx_bit | input | 1 | Raw received bit |
| brk_phase | input | 1 | Sync break field is being transmitted |
| stop_bit | input | 1 | Sampled stop bit |
| ctype_sel | input | 1 | Checksum-type select from the engine |
| sync_err | input | 1 | Raw sync-field error from the engine |
| bitmon_bit | output | 1 | Bit to the bit monitor |
| stopchk_bit | output | 1 | Stop bit to the frame checker |
| ctype_rx | output | 1 | Checksum-type select to the receive checksum unit |
| sync_err_flag | output | 1 | Sync-field error flag, suppressed in test mode |
| sync_skew_req | output | 1 | Request to the engine to skew sync-field bit widths |
| lpbk_en | output | 1 | Loopback enable, gated by test mode |
| rxpin_en | output | 1 | Receive-pin select, gated by test mode |

## Verification
The datapath outputs are combinational, so they are due in the same cycle as their inputs. The bench changes inputs at a falling edge and samples them one nanosecond later, before any clock edge can occur. Control-word and mode-state results are due one rising edge after the strobe. The bench raises `reg_wr_en` at a falling edge and drops it at the next falling edge, then reads `reg_rdata`, `test_active` and the gated path selects at that same falling edge. Every table entry first writes its configuration in this way, and only then applies its datapath stimulus.

// File: rtl/rx_fault_pkg.sv
package rx_fault_pkg;

    localparam int CTRL_W     = 32;
    localparam int POS_BITF   = 31;
    localparam int POS_BUSF   = 30;
    localparam int POS_CSUMF  = 29;
    localparam int POS_SYNCF  = 28;
    localparam int POS_FRAMEF = 26;
    localparam int POS_KEY_LO = 8;
    localparam int POS_LPBK   = 1;
    localparam int POS_RXPIN  = 0;
    localparam int LIN_GRP_N  = 4;   // bits 31:28, written only in LIN mode

    localparam logic [CTRL_W-1:0] USED_MASK = 32'hF400_0F03;

    typedef struct packed {
        logic bit_f;
        logic bus_f;
        logic csum_f;
        logic sync_f;
        logic frame_f;
        logic lpbk;
        logic rxpin;
    } fault_cfg_t;

    typedef enum logic [0:0] {
        ST_LOCKED = 1'b0,
        ST_TEST   = 1'b1
    } tm_state_e;

endpackage

// File: rtl/fi_ctrl_reg.sv
module fi_ctrl_reg
    import rx_fault_pkg::*;
#(
    parameter int          KEY_W     = 4,
    parameter logic [3:0]  KEY_RESET = 4'h5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                priv,
    input  logic                lin_mode,
    input  logic [CTRL_W-1:0]   wdata,
    output fault_cfg_t          cfg,
    output logic [KEY_W-1:0]    key,
    output logic [CTRL_W-1:0]   rdata
);

    localparam int LIN_TOP = POS_BITF;

    logic [LIN_GRP_N-1:0] lin_bits;
    logic                 frame_q;
    logic                 lpbk_q;
    logic                 rxpin_q;
    logic                 lin_wr;
    logic                 priv_wr;

    assign lin_wr  = wr_en && lin_mode;
    assign priv_wr = wr_en && priv;

    // LIN-qualified fault enables, one flop per bit
    for (genvar g = 0; g < LIN_GRP_N; g++) begin : g_lin_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lin_bits[g] <= 1'b0;
            else if (lin_wr)
                lin_bits[g] <= wdata[LIN_TOP - (LIN_GRP_N - 1) + g];
        end
    end

    // Frame fault: writable on every access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            frame_q <= 1'b0;
        else if (wr_en)
            frame_q <= wdata[POS_FRAMEF];
    end

    // Privileged fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key     <= KEY_RESET[KEY_W-1:0];
            lpbk_q  <= 1'b0;
            rxpin_q <= 1'b0;
        end else if (priv_wr) begin
            key     <= wdata[POS_KEY_LO +: KEY_W];
            lpbk_q  <= wdata[POS_LPBK];
            rxpin_q <= wdata[POS_RXPIN];
        end
    end

    always_comb begin
        cfg.bit_f   = lin_bits[3];
        cfg.bus_f   = lin_bits[2];
        cfg.csum_f  = lin_bits[1];
        cfg.sync_f  = lin_bits[0];
        cfg.frame_f = frame_q;
        cfg.lpbk    = lpbk_q;
        cfg.rxpin   = rxpin_q;
    end

    always_comb begin
        rdata                        = '0;
        rdata[POS_BITF]              = lin_bits[3];
        rdata[POS_BUSF]              = lin_bits[2];
        rdata[POS_CSUMF]             = lin_bits[1];
        rdata[POS_SYNCF]             = lin_bits[0];
        rdata[POS_FRAMEF]            = frame_q;
        rdata[POS_KEY_LO +: KEY_W]   = key;
        rdata[POS_LPBK]              = lpbk_q;
        rdata[POS_RXPIN]             = rxpin_q;
    end

    // R3
    lin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && lin_mode) |=> $stable(lin_bits));

    // R4
    priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && priv) |=> ($stable(key) && $stable(lpbk_q) && $stable(rxpin_q)));

endmodule

// File: rtl/fi_mode_fsm.sv
module fi_mode_fsm
    import rx_fault_pkg::*;
#(
    parameter int          KEY_W      = 4,
    parameter logic [3:0]  KEY_UNLOCK = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              priv,
    input  logic [KEY_W-1:0]  wkey,
    output tm_state_e         state,
    output logic              test_active
);

    tm_state_e state_nx;
    logic      key_wr;
    logic      key_hit;

    assign key_wr  = wr_en && priv;
    assign key_hit = (wkey == KEY_UNLOCK[KEY_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_LOCKED;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKED: if (key_wr && key_hit)  state_nx = ST_TEST;    // KEY_MATCH
            ST_TEST:   if (key_wr && !key_hit) state_nx = ST_LOCKED;  // KEY_MISS
            default:   state_nx = ST_LOCKED;
        endcase
    end

    always_comb begin
        test_active = 1'b0;
        unique case (state)
            ST_LOCKED: test_active = 1'b0;
            ST_TEST:   test_active = 1'b1;
            default:   test_active = 1'b0;
        endcase
    end

    // R12
    mode_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && priv) |=> $stable(state));

endmodule

// File: rtl/fi_inject.sv
module fi_inject
    import rx_fault_pkg::*;
(
    input  fault_cfg_t cfg,
    input  logic       test_active,
    input  logic       rx_bit,
    input  logic       brk_phase,
    input  logic       stop_bit,
    input  logic       ctype_sel,
    input  logic       sync_err,
    output logic       bitmon_bit,
    output logic       stopchk_bit,
    output logic       ctype_rx,
    output logic       sync_err_flag,
    output logic       sync_skew_req,
    output logic       lpbk_en,
    output logic       rxpin_en
);

    logic force_one;

    always_comb begin
        force_one     = test_active && (cfg.bit_f || (cfg.bus_f && brk_phase));
        bitmon_bit    = rx_bit | force_one;
        stopchk_bit   = stop_bit & ~(test_active && cfg.frame_f);
        ctype_rx      = ctype_sel ^ (test_active && cfg.csum_f);
        sync_err_flag = sync_err & ~test_active;
        sync_skew_req = test_active && cfg.sync_f;
        lpbk_en       = test_active && cfg.lpbk;
        rxpin_en      = test_active && cfg.rxpin;
    end

endmodule

// File: rtl/rx_fault_inject.sv
module rx_fault_inject
    import rx_fault_pkg::*;
#(
    parameter int          KEY_W      = 4,
    parameter logic [3:0]  KEY_RESET  = 4'h5,
    parameter logic [3:0]  KEY_UNLOCK = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_priv,
    input  logic              lin_mode,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    output logic              test_active,
    input  logic              rx_bit,
    input  logic              brk_phase,
    input  logic              stop_bit,
    input  logic              ctype_sel,
    input  logic              sync_err,
    output logic              bitmon_bit,
    output logic              stopchk_bit,
    output logic              ctype_rx,
    output logic              sync_err_flag,
    output logic              sync_skew_req,
    output logic              lpbk_en,
    output logic              rxpin_en
);

    fault_cfg_t       cfg;
    logic [KEY_W-1:0] key;
    tm_state_e        state;

    fi_ctrl_reg #(.KEY_W(KEY_W), .KEY_RESET(KEY_RESET)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .priv     (reg_priv),
        .lin_mode (lin_mode),
        .wdata    (reg_wdata),
        .cfg      (cfg),
        .key      (key),
        .rdata    (reg_rdata)
    );

    fi_mode_fsm #(.KEY_W(KEY_W), .KEY_UNLOCK(KEY_UNLOCK)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .priv        (reg_priv),
        .wkey        (reg_wdata[POS_KEY_LO +: KEY_W]),
        .state       (state),
        .test_active (test_active)
    );

    fi_inject u_inj (
        .cfg           (cfg),
        .test_active   (test_active),
        .rx_bit        (rx_bit),
        .brk_phase     (brk_phase),
        .stop_bit      (stop_bit),
        .ctype_sel     (ctype_sel),
        .sync_err      (sync_err),
        .bitmon_bit    (bitmon_bit),
        .stopchk_bit   (stopchk_bit),
        .ctype_rx      (ctype_rx),
        .sync_err_flag (sync_err_flag),
        .sync_skew_req (sync_skew_req),
        .lpbk_en       (lpbk_en),
        .rxpin_en      (rxpin_en)
    );

    // R6
    key_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_active == (key == KEY_UNLOCK[KEY_W-1:0]));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~USED_MASK) == '0);

    // R7
    bit_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active && reg_rdata[POS_BITF]) |-> bitmon_bit);

    // R10
    frame_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active && reg_rdata[POS_FRAMEF]) |-> !stopchk_bit);

    // R11
    sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_active |-> !sync_err_flag);

    // R13
    path_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_active |-> (!lpbk_en && !rxpin_en));

endmodule

// File: tb/rx_fault_inject_tb_top.sv
module rx_fault_inject_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_priv = 1'b0;
    logic        lin_mode = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        test_active;
    logic        rx_bit = 1'b0, brk_phase = 1'b0, stop_bit = 1'b0, ctype_sel = 1'b0, sync_err = 1'b0;
    logic        bitmon_bit, stopchk_bit, ctype_rx, sync_err_flag, sync_skew_req, lpbk_en, rxpin_en;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    rx_fault_inject dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_priv(reg_priv),
        .lin_mode(lin_mode), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .test_active(test_active), .rx_bit(rx_bit), .brk_phase(brk_phase),
        .stop_bit(stop_bit), .ctype_sel(ctype_sel), .sync_err(sync_err),
        .bitmon_bit(bitmon_bit), .stopchk_bit(stopchk_bit), .ctype_rx(ctype_rx),
        .sync_err_flag(sync_err_flag), .sync_skew_req(sync_skew_req),
        .lpbk_en(lpbk_en), .rxpin_en(rxpin_en)
    );

    // entry: {enables bit,bus,csum,sync,frame}{unlocked}{in rx,brk,stop,ctype,serr}{exp bitmon,stopchk,ctype,serr,skew}
    localparam int NV = 13;
    localparam logic [15:0] VEC [NV] = '{
        {5'b10000, 1'b0, 5'b00101, 5'b01010},  // R6 locked pass-through
        {5'b10000, 1'b1, 5'b00101, 5'b11000},  // R7
        {5'b01000, 1'b1, 5'b00100, 5'b01000},  // R8 no break
        {5'b01000, 1'b1, 5'b01100, 5'b11000},  // R8 in break
        {5'b01000, 1'b0, 5'b01100, 5'b01000},  // R6
        {5'b00100, 1'b1, 5'b10100, 5'b11100},  // R9 0->1
        {5'b00100, 1'b1, 5'b10110, 5'b11000},  // R9 1->0
        {5'b00010, 1'b1, 5'b00101, 5'b01001},  // R11
        {5'b00010, 1'b0, 5'b00101, 5'b01010},  // R6
        {5'b00001, 1'b1, 5'b10110, 5'b10100},  // R10
        {5'b00001, 1'b0, 5'b10110, 5'b11100},  // R6
        {5'b00000, 1'b1, 5'b00101, 5'b01000},  // R11 suppression
        {5'b11111, 1'b1, 5'b01101, 5'b10101}   // R7 R9 R10 R11 combined
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d, input logic p, input logic l);
        @(negedge clk);
        reg_wdata = d; reg_priv = p; lin_mode = l; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_priv = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", reg_rdata, 32'h0000_0500);
        check("R1", {lpbk_en, rxpin_en, test_active}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5: unprivileged, non-LIN: only frame bit moves
        do_write(32'hFFFF_FFFF, 1'b0, 1'b0);
        check("R5", reg_rdata, 32'h0400_0500);
        // R3: LIN-mode unprivileged: bits 31:28 also move
        do_write(32'hFFFF_FFFF, 1'b0, 1'b1);
        check("R3", reg_rdata, 32'hF400_0500);
        // R4: privileged non-LIN clear: 31:28 held
        do_write(32'h0000_0000, 1'b1, 1'b0);
        check("R4", reg_rdata, 32'hF000_0000);
        // R12 R13 R6: unlock
        do_write(32'h0000_0A03, 1'b1, 1'b1);
        check("R12", reg_rdata, 32'h0000_0A03);
        check("R13", {test_active, lpbk_en, rxpin_en}, 3'b111);
        // R2: reserved ignored; key F locks
        do_write(32'hFFFF_FFFF, 1'b1, 1'b1);
        check("R2", reg_rdata, 32'hF400_0F03);
        check("R6", {test_active, lpbk_en, rxpin_en}, 3'b000);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] w;
            w = '0;
            w[31:28] = VEC[i][15:12];
            w[26]    = VEC[i][11];
            w[11:8]  = VEC[i][10] ? 4'hA : 4'h5;
            do_write(w, 1'b1, 1'b1);
            check("R6 R12 mode", {31'b0, test_active}, {31'b0, VEC[i][10]});
            {rx_bit, brk_phase, stop_bit, ctype_sel, sync_err} = VEC[i][9:5];
            #1;
            check($sformatf("R7-R11 vec%0d", i),
                  {27'b0, bitmon_bit, stopchk_bit, ctype_rx, sync_err_flag, sync_skew_req},
                  {27'b0, VEC[i][4:0]});
        end

        // R12: same-cycle response to an input change within one phase
        brk_phase = 1'b0; rx_bit = 1'b0;
        do_write(32'h4000_0A00, 1'b1, 1'b1);
        brk_phase = 1'b1; #1;
        check("R8 R12", {31'b0, bitmon_bit}, 32'd1);
        brk_phase = 1'b0; #1;
        check("R8 R12", {31'b0, bitmon_bit}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule